// File: doc/BRIEF.md
# Transmit Queue Start/Stop Gate

This block decides, for each of up to sixteen transmit queues, whether the queue is running. Software turns queues on by writing ones into a set-only enable word and asks for them to stop by writing ones into a stop-request word. A stop request does not take effect at once. The queue keeps running until every frame it still holds has left, and only then does its run bit drop. A per-queue flush option lets the held frames be thrown away at one per cycle instead of waiting for each to be sent.

Each queue also has a 32-bit descriptor pointer word and a status word that reports how many frames the queue holds. Software may change a pointer only while its queue is stopped. A pointer write to a running queue changes nothing and raises a one-cycle error pulse. The frame traffic itself is modelled by two pulse vectors, one bit per queue: one pulse adds a frame and the other retires a frame.

Register access uses a single-cycle bus with word addresses and a 32-bit data width. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `txq_gate`

## Requirements
- R1: After reset, every run bit, stop request, flush bit, descriptor pointer and held-frame count is zero, and `ptr_err` is low.
- R2: A write to word 0x00 sets the run bit of every queue whose data bit is 1. Queues whose data bit is 0 keep their state. Reading word 0x00 returns the run bits.
- R3: A nonzero write to word 0x01 adds stop requests for the queues whose data bit is 1. A queue with a stop request keeps its run bit set for as long as its held-frame count is nonzero.
- R4: A queue's run bit and its stop request both clear at the clock edge that ends the first cycle in which the request is pending and the count is zero. For a queue holding no frames, that is the second edge after the stop write.
- R5: Writing zero to word 0x01 withdraws every pending stop request, so those queues keep running. Reading word 0x01 returns the pending requests.
- R6: Word 0x20+q bits [5:0] hold queue q's frame count. An add pulse raises the count by one and a retire pulse lowers it by one. Both together leave it unchanged. An add at the maximum of 63 is dropped, and a retire at zero is dropped.
- R7: Word 0x02 holds one flush bit per queue. In every cycle that begins with the queue's flush bit set and its count nonzero, one frame is discarded.
- R8: A write to word 0x10+q stores a 32-bit pointer when queue q is stopped. When queue q is running, the write is ignored and `ptr_err` is high for the following cycle only.
- R9: A stop takes priority over a start. An enable write that arrives while a stop request is completing does not leave the queue running.
- R10: Reads of unmapped words (0x03 to 0x0F, and 0x30 to 0x3F) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| frm_push | input | NQ | Per-queue frame-added pulse |
| frm_done | input | NQ | Per-queue frame-retired pulse |
| q_active | output | NQ | Per-queue run bits |
| ptr_err | output | 1 | Rejected pointer write, one cycle |

## Verification
The assertions check several rules on every cycle. A run bit falls only on an edge where a request was pending and the count was zero. A running queue with frames held stays running. A running queue's pointer never changes. The count rises only after an add pulse. A zero stop write empties the request set. The bench scenarios are needed to show the exact edge at which a drained queue stops, the flush rate, saturation at 63, the start-versus-stop priority, and the values seen through the read map.

// File: rtl/txq_gate.sv
module txq_gate #(
  parameter int NQ    = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NQ-1:0]    frm_push,
  input  logic [NQ-1:0]    frm_done,
  output logic [NQ-1:0]    q_active,
  output logic             ptr_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;

  logic [NQ-1:0]    en_q, req_q, early_q, idle, stop;
  logic [CNT_W-1:0] cnt_q [NQ];
  logic [31:0]      ptr_q [NQ];

  wire [3:0] idx     = bus_addr[3:0];
  wire       idx_ok  = 32'(idx) < NQ;
  wire [IW-1:0] qi   = IW'(idx);
  wire       wr_run  = bus_we && bus_addr == 6'h00;
  wire       wr_stop = bus_we && bus_addr == 6'h01;
  wire       wr_fl   = bus_we && bus_addr == 6'h02;
  wire       is_ptr  = bus_addr[5:4] == 2'b01;
  wire       is_sts  = bus_addr[5:4] == 2'b10;
  wire [NQ-1:0] wq   = bus_wdata[NQ-1:0];

  assign stop     = req_q & idle;
  assign q_active = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      req_q   <= '0;
      early_q <= '0;
      ptr_err <= 1'b0;
    end else begin
      en_q    <= (en_q | (wr_run ? wq : '0)) & ~stop;
      if (wr_stop)
        req_q <= (wq == '0) ? '0 : ((req_q | wq) & ~stop);
      else
        req_q <= req_q & ~stop;
      if (wr_fl) early_q <= wq;
      ptr_err <= bus_we && is_ptr && idx_ok && en_q[qi];
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic inc, dec;
    assign idle[i] = cnt_q[i] == '0;
    assign inc = frm_push[i] && cnt_q[i] != CNT_MAX;
    assign dec = !idle[i] && (frm_done[i] || early_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        ptr_q[i] <= '0;
      end else begin
        case ({inc, dec})
          2'b10:   cnt_q[i] <= cnt_q[i] + 1'b1;
          2'b01:   cnt_q[i] <= cnt_q[i] - 1'b1;
          default: cnt_q[i] <= cnt_q[i];
        endcase
        if (bus_we && is_ptr && 32'(idx) == i && !en_q[i])
          ptr_q[i] <= bus_wdata;
      end
    end

    assert_en_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[i]) |-> $past(req_q[i] && cnt_q[i] == '0));
    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && cnt_q[i] != '0) |=> en_q[i]);
    assert_ptr_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |=> $stable(ptr_q[i]));
    assert_cnt_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] > $past(cnt_q[i])) |-> $past(frm_push[i]));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 6'h00)      bus_rdata[NQ-1:0] = en_q;
    else if (bus_addr == 6'h01) bus_rdata[NQ-1:0] = req_q;
    else if (bus_addr == 6'h02) bus_rdata[NQ-1:0] = early_q;
    else if (is_ptr && idx_ok)  bus_rdata = ptr_q[qi];
    else if (is_sts && idx_ok)  bus_rdata[CNT_W-1:0] = cnt_q[qi];
  end

  assert_err_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_err |-> $past(bus_we && is_ptr));
  assert_req_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stop && wq == '0) |=> req_q == '0);
endmodule

// File: tb/txq_gate_tb.sv
module txq_gate_tb;
  localparam int CLK_NS = 10;
  localparam int NQ = 16;
  localparam int NV = 18;

  logic clk = 0, rst_n = 0, bus_we = 0, ptr_err;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NQ-1:0] frm_push = 0, frm_done = 0, q_active;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  txq_gate #(.NQ(NQ), .CNT_W(6)) u_dut (.*);

  // {write?, addr, data}: write rows drive data, read rows compare data
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 6'h00, 32'h0000_0005},  // R2
    {1'b0, 6'h00, 32'h0000_0005},
    {1'b1, 6'h00, 32'h0000_0100},
    {1'b0, 6'h00, 32'h0000_0105},  // R2 others untouched
    {1'b1, 6'h02, 32'h0000_00F0},  // R7
    {1'b0, 6'h02, 32'h0000_00F0},
    {1'b0, 6'h3F, 32'h0},          // R10
    {1'b0, 6'h0F, 32'h0},          // R10
    {1'b1, 6'h11, 32'hDEAD_BEEF},  // R8 stopped queue
    {1'b0, 6'h11, 32'hDEAD_BEEF},
    {1'b1, 6'h10, 32'h0000_1234},  // R8 running queue
    {1'b0, 6'h10, 32'h0},
    {1'b1, 6'h01, 32'h0000_0004},  // R3
    {1'b0, 6'h01, 32'h0000_0004},
    {1'b0, 6'h00, 32'h0000_0101},  // R4 second edge
    {1'b0, 6'h01, 32'h0},          // R4
    {1'b1, 6'h02, 32'h0},
    {1'b0, 6'h02, 32'h0}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, tag);
    @(negedge clk);
  endtask

  task automatic pulse(input int q, input bit push, input bit done);
    frm_push[q] = push; frm_done[q] = done;
    @(negedge clk);
    frm_push[q] = 0; frm_done[q] = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(6'h00, 0, "R1 run bits");
    rd(6'h01, 0, "R1 requests");
    rd(6'h02, 0, "R1 flush bits");
    rd(6'h10, 0, "R1 pointer");
    rd(6'h20, 0, "R1 count");
    check({31'd0, ptr_err}, 0, "R1 ptr_err");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][38]) wr(VEC[k][37:32], VEC[k][31:0]);
      else rd(VEC[k][37:32], VEC[k][31:0], $sformatf("R2-R10 table row %0d", k));
    end

    // R3/R4/R6: drain by retire pulses
    wr(6'h00, 32'h8);
    repeat (3) pulse(3, 1, 0);
    rd(6'h23, 3, "R6 count after adds");
    wr(6'h01, 32'h8);
    repeat (2) @(negedge clk);
    check({31'd0, q_active[3]}, 1, "R3 held while frames remain");
    repeat (3) pulse(3, 0, 1);
    check({31'd0, q_active[3]}, 1, "R4 still running at count zero");
    rd(6'h23, 0, "R6 drained");
    check({31'd0, q_active[3]}, 0, "R4 stopped after drain");

    // R6 corner cases
    pulse(12, 0, 1);
    rd(6'h2C, 0, "R6 retire at zero");
    pulse(13, 1, 0); pulse(13, 1, 0);
    pulse(13, 1, 1);
    rd(6'h2D, 2, "R6 add and retire together");
    frm_push[4] = 1;
    repeat (70) @(negedge clk);
    frm_push[4] = 0;
    rd(6'h24, 63, "R6 saturation");

    // R7: flush one per cycle
    repeat (4) pulse(9, 1, 0);
    wr(6'h02, 32'h200);
    rd(6'h29, 4, "R7 flush not yet started");
    rd(6'h29, 3, "R7 first discard");
    repeat (3) @(negedge clk);
    rd(6'h29, 0, "R7 fully flushed");
    wr(6'h02, 32'h0);

    // R8: rejected pointer write
    wr(6'h00, 32'h40);
    wr(6'h16, 32'hAAAA_5555);
    check({31'd0, ptr_err}, 1, "R8 error pulse");
    rd(6'h16, 0, "R8 pointer unchanged");
    check({31'd0, ptr_err}, 0, "R8 pulse is one cycle");

    // R9: start during a completing stop
    wr(6'h01, 32'h400);
    wr(6'h00, 32'h400);
    check({31'd0, q_active[10]}, 0, "R9 stop wins");
    rd(6'h01, 0, "R9 request retired");

    // R5: withdraw requests
    pulse(11, 1, 0);
    wr(6'h00, 32'h800);
    wr(6'h01, 32'h800);
    rd(6'h01, 32'h800, "R5 request pending");
    wr(6'h01, 32'h0);
    rd(6'h01, 0, "R5 requests wiped");
    pulse(11, 0, 1);
    repeat (2) @(negedge clk);
    check({31'd0, q_active[11]}, 1, "R5 queue keeps running");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule